// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Pipeline

This block is a clockless FIFO-style pipeline for words of `WIDTH` bits. It is made of `STAGES` half-latch stages. Each bit travels on a pair of wires, a true rail and a false rail. A word is valid when every bit has exactly one rail high. The word is empty when every rail is low. Because validity is carried by the code itself, there is no request wire. Each stage answers its predecessor with a single acknowledge, and that acknowledge comes from a completion detector built over its stored word.

A stage stores through level-sensitive C-elements. One input of each C-element is the incoming rail. The other is the inverted acknowledge of the stage after it. A stage therefore takes a new valid word only after its successor has drained, and it takes the empty spacer only after its successor has captured the word. A transfer on either edge of the block follows four phases:

1. The sender drives a valid word.
2. The acknowledge rises.
3. The sender returns every rail to low.
4. The acknowledge falls.

The block sits between two such handshaking parties. An active-low reset empties every stage latch.

Top module: `dr_pipe`

## Requirements
- R1: Bit encoding is {true rail, false rail}: 00 is empty, 10 is a valid one, 01 is a valid zero. No stage and no output bit ever shows 11 while the inputs obey the protocol.
- R2: While `rst_n` is low, every stage is empty, `din_ack` is 0 and both output rail vectors are 0, even if a valid word is presented at the input. After release with an empty input they stay that way.
- R3: Every word accepted at the input leaves at the output with its value unchanged, in the order of acceptance. The output value is read from `dout_t` (bit i is 1 when `dout_t[i]` is high).
- R4: The output word never changes from one all-valid value to another without first passing through the all-empty state.
- R5: `din_ack` rises only once every bit of the input word is valid. A word with only some bits valid is never acknowledged.
- R6: Once raised, `din_ack` stays high until every input bit has returned to empty. Clearing only some bits leaves it high.
- R7: With `dout_ack` held low, the pipeline accepts exactly ceil(STAGES/2) words, because every held word is separated from the next by an empty stage. A further word offered at the input gets no acknowledge. Meanwhile the output holds the first word steadily. When the receiver resumes, all words, including the waiting one, leave in order.
- R8: Consecutive identical words, including all-zero and all-one words, are delivered as separate tokens, one per input handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset, empties every stage latch |
| din_t | input | WIDTH | True rails of the incoming word |
| din_f | input | WIDTH | False rails of the incoming word |
| din_ack | output | 1 | Acknowledge to the sender (completion of the first stage) |
| dout_t | output | WIDTH | True rails of the outgoing word |
| dout_f | output | WIDTH | False rails of the outgoing word |
| dout_ack | input | 1 | Acknowledge from the receiver |

## Verification
Two functions can coincide in one event cascade: the output stage releasing a word to the receiver, and the first stage accepting a word that has been waiting at the input. The stalled-receiver scenario sets this up. It fills the pipeline to capacity, parks one extra word on the input, and then lets the receiver acknowledge, so the drain at the output and the capture at the input ripple through in the same moment. The result is judged at the ports: the parked word must receive its acknowledge, and all words must leave in offering order with values intact. The output must never step between two valid words without an empty spacer.

// File: rtl/dr_pipe_pkg.sv
`timescale 1ns/1ps
package dr_pipe_pkg;

  // Per-bit rail code, written as {true rail, false rail}
  typedef enum logic [1:0] {
    DR_EMPTY = 2'b00,
    DR_ZERO  = 2'b01,
    DR_ONE   = 2'b10,
    DR_BAD   = 2'b11
  } dr_bit_e;

  function automatic dr_bit_e dr_code(input logic t, input logic f);
    return dr_bit_e'({t, f});
  endfunction

endpackage

// File: rtl/dr_cel.sv
`timescale 1ns/1ps
// Two-input C-element without reset: output follows the inputs when they agree.
module dr_cel (
  input  logic a,
  input  logic b,
  output logic y
);
  always_latch begin
    if (a == b) y <= a;
  end
endmodule

// File: rtl/dr_celr.sv
`timescale 1ns/1ps
// Two-input C-element with asynchronous active-low clear.
module dr_celr (
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic y
);
  always_latch begin
    if (!rst_n)      y <= 1'b0;
    else if (a == b) y <= a;
  end
endmodule

// File: rtl/dr_done.sv
`timescale 1ns/1ps
// Completion detector: a heap-ordered tree of C-elements over per-bit flags.
module dr_done #(
  parameter int W = 8
) (
  input  logic [W-1:0] leaf,
  output logic         done
);
  localparam int NODES = 2 * W - 1;

  logic [NODES-1:0] nd;

  assign nd[NODES-1 -: W] = leaf;

  for (genvar i = 0; i < W - 1; i++) begin : g_node
    dr_cel u_cel (
      .a (nd[2*i+1]),
      .b (nd[2*i+2]),
      .y (nd[i])
    );
  end

  assign done = nd[0];
endmodule

// File: rtl/dr_stage.sv
`timescale 1ns/1ps
// One half-latch stage: two C-elements per bit plus completion detection.
module dr_stage #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  input  logic         ack_nxt,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f,
  output logic         done
);
  logic         go;
  logic [W-1:0] held;

  assign go = ~ack_nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    dr_celr u_t (.rst_n(rst_n), .a(in_t[i]), .b(go), .y(out_t[i]));
    dr_celr u_f (.rst_n(rst_n), .a(in_f[i]), .b(go), .y(out_f[i]));
  end

  assign held = out_t | out_f;

  dr_done #(.W(W)) u_done (
    .leaf (held),
    .done (done)
  );
endmodule

// File: rtl/dr_pipe.sv
`timescale 1ns/1ps
// Chain of dual-rail half-latch stages.
module dr_pipe #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 4
) (
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_t,
  input  logic [WIDTH-1:0] din_f,
  output logic             din_ack,
  output logic [WIDTH-1:0] dout_t,
  output logic [WIDTH-1:0] dout_f,
  input  logic             dout_ack
);
  localparam int W = WIDTH;
  localparam int S = STAGES;

  // Index 0 is the block input, index k is the output of stage k-1.
  logic [S:0][W-1:0] rt;
  logic [S:0][W-1:0] rf;
  // ak[k] is the completion of stage k, ak[S] is the receiver's acknowledge.
  logic [S:0]        ak;

  assign rt[0] = din_t;
  assign rf[0] = din_f;
  assign ak[S] = dout_ack;

  for (genvar k = 0; k < S; k++) begin : g_stage
    dr_stage #(.W(W)) u_stage (
      .rst_n   (rst_n),
      .in_t    (rt[k]),
      .in_f    (rf[k]),
      .ack_nxt (ak[k+1]),
      .out_t   (rt[k+1]),
      .out_f   (rf[k+1]),
      .done    (ak[k])
    );
  end

  assign din_ack = ak[0];
  assign dout_t  = rt[S];
  assign dout_f  = rf[S];
endmodule

// File: rtl/dr_pipe_chk.sv
`timescale 1ns/1ps
module dr_pipe_chk #(
  parameter int W = 8,
  parameter int S = 4
) (
  input logic             rst_n,
  input logic [S:0][W-1:0] rt,
  input logic [S:0][W-1:0] rf,
  input logic             din_ack,
  input logic [W-1:0]     dout_t,
  input logic [W-1:0]     dout_f
);
  import dr_pipe_pkg::*;

  // R1
  always_comb begin
    for (int k = 1; k <= S; k++) begin
      for (int i = 0; i < W; i++) begin
        no_bad_code_chk: assert (dr_code(rt[k][i], rf[k][i]) != DR_BAD)
          else $error("stage %0d bit %0d shows both rails high", k - 1, i);
      end
    end
  end

  // R2
  for (genvar k = 1; k <= S; k++) begin : g_rst
    always @(rt[k] or rf[k]) begin
      if (!rst_n) begin
        // R2
        reset_empty_chk: assert (rt[k] == '0 && rf[k] == '0)
          else $error("stage %0d changed to non-empty under reset", k - 1);
      end
    end
  end

  always @(din_ack) begin
    if (!rst_n) begin
      // R2
      reset_ack_low_chk: assert (!din_ack)
        else $error("input acknowledge rose under reset");
    end else if (din_ack) begin
      // R5
      ack_full_word_chk: assert (&(rt[1] ^ rf[1]))
        else $error("input acknowledge rose on an incomplete word");
    end else begin
      // R6
      ack_empty_word_chk: assert ((rt[1] | rf[1]) == '0)
        else $error("input acknowledge fell while stage 0 still held data");
    end
  end

  logic [W-1:0] last_word;
  logic         armed;

  always @(dout_t or dout_f or rst_n) begin
    if (!rst_n) begin
      armed = 1'b0;
    end else if ((dout_t | dout_f) == '0) begin
      armed = 1'b0;
    end else if (&(dout_t ^ dout_f)) begin
      if (armed) begin
        // R4
        no_skip_spacer_chk: assert (dout_t == last_word)
          else $error("output moved between valid words without a spacer");
      end
      last_word = dout_t;
      armed     = 1'b1;
    end
  end
endmodule

bind dr_pipe dr_pipe_chk #(.W(WIDTH), .S(STAGES)) u_chk (
  .rst_n   (rst_n),
  .rt      (rt),
  .rf      (rf),
  .din_ack (din_ack),
  .dout_t  (dout_t),
  .dout_f  (dout_f)
);

// File: tb/tb_dr_pipe.sv
`timescale 1ns/1ps
module tb_dr_pipe;
  localparam int N   = 8;
  localparam int S   = 4;
  localparam int CAP = (S + 1) / 2;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] din_t, din_f, dout_t, dout_f;
  logic         din_ack, dout_ack;

  int n_chk  = 0;
  int n_fail = 0;
  int n_bad  = 0;
  int n_skip = 0;
  logic [N-1:0] exp_q[$];

  dr_pipe #(.WIDTH(N), .STAGES(S)) dut (
    .rst_n(rst_n), .din_t(din_t), .din_f(din_f), .din_ack(din_ack),
    .dout_t(dout_t), .dout_f(dout_f), .dout_ack(dout_ack)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Port monitors for R1 and R4
  logic [N-1:0] mon_last;
  logic         mon_armed = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((dout_t & dout_f) != '0) n_bad++;
      if ((dout_t | dout_f) == '0) mon_armed <= 1'b0;
      else if (&(dout_t ^ dout_f)) begin
        if (mon_armed && dout_t != mon_last) n_skip++;
        mon_last  <= dout_t;
        mon_armed <= 1'b1;
      end
    end
  end

  task automatic put_token(input logic [N-1:0] v);
    do @(negedge clk); while (din_ack);
    @(posedge clk);
    din_t = v;
    din_f = ~v;
    do @(negedge clk); while (!din_ack);
    repeat ($urandom_range(0, 3)) @(posedge clk);
    @(posedge clk);
    din_t = '0;
    din_f = '0;
    do @(negedge clk); while (din_ack);
  endtask

  task automatic get_token(output logic [N-1:0] v);
    do @(negedge clk); while (!(&(dout_t ^ dout_f)));
    repeat ($urandom_range(0, 3)) @(negedge clk);
    v = dout_t;
    @(posedge clk);
    dout_ack = 1'b1;
    do @(negedge clk); while ((dout_t | dout_f) != '0);
    repeat ($urandom_range(0, 3)) @(posedge clk);
    @(posedge clk);
    dout_ack = 1'b0;
  endtask

  task automatic recv_expect(input string req);
    logic [N-1:0] got, want;
    get_token(got);
    want = exp_q.pop_front();
    chk(got == want, req, 64'(got), 64'(want));
  endtask

  // R2: reset empties the pipeline even with a valid word presented
  task automatic t_reset();
    rst_n = 1'b0; din_t = '0; din_f = '0; dout_ack = 1'b0;
    repeat (3) @(posedge clk);
    din_t = 8'hA5; din_f = ~8'hA5;
    repeat (4) @(negedge clk);
    chk(din_ack == 1'b0, "R2 ack under reset", 64'(din_ack), 64'd0);
    chk((dout_t | dout_f) == '0, "R2 output empty under reset",
        64'(dout_t | dout_f), 64'd0);
    @(posedge clk);
    din_t = '0; din_f = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(din_ack == 1'b0, "R2 ack after release", 64'(din_ack), 64'd0);
    chk((dout_t | dout_f) == '0, "R2 output empty after release",
        64'(dout_t | dout_f), 64'd0);
  endtask

  // R5 and R6: completion on partial words
  task automatic t_partial();
    logic [N-1:0] v = 8'h3C;
    exp_q.push_back(v);
    fork
      begin
        @(posedge clk);
        for (int i = 0; i < N - 1; i++) begin
          din_t[i] = v[i]; din_f[i] = ~v[i];
          @(posedge clk);
        end
        repeat (4) @(negedge clk);
        chk(din_ack == 1'b0, "R5 partial word not acknowledged", 64'(din_ack), 64'd0);
        @(posedge clk);
        din_t[N-1] = v[N-1]; din_f[N-1] = ~v[N-1];
        repeat (3) @(negedge clk);
        chk(din_ack == 1'b1, "R5 full word acknowledged", 64'(din_ack), 64'd1);
        for (int i = 0; i < N - 1; i++) begin
          @(posedge clk);
          din_t[i] = 1'b0; din_f[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk(din_ack == 1'b1, "R6 ack held on partial clear", 64'(din_ack), 64'd1);
        @(posedge clk);
        din_t = '0; din_f = '0;
        repeat (3) @(negedge clk);
        chk(din_ack == 1'b0, "R6 ack drops on full clear", 64'(din_ack), 64'd0);
      end
      recv_expect("R3 value of partially built word");
    join
  endtask

  // R3: random stream with random stalls on both sides
  task automatic t_stream(input int n);
    fork
      for (int i = 0; i < n; i++) begin
        logic [N-1:0] v = N'($urandom);
        exp_q.push_back(v);
        put_token(v);
      end
      for (int i = 0; i < n; i++) recv_expect("R3 stream order and value");
    join
  endtask

  // R8: repeated identical words stay separate tokens
  task automatic t_repeat();
    logic [N-1:0] pat[6] = '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00};
    fork
      for (int i = 0; i < 6; i++) begin
        exp_q.push_back(pat[i]);
        put_token(pat[i]);
      end
      for (int i = 0; i < 6; i++) recv_expect("R8 repeated word delivered");
    join
    repeat (10) @(negedge clk);
    chk((dout_t | dout_f) == '0, "R8 no extra token", 64'(dout_t | dout_f), 64'd0);
  endtask

  // R7: capacity with a stalled receiver, then release
  task automatic t_capacity();
    int accepted = 0;
    bit refused  = 1'b0;
    for (int i = 0; i <= CAP && !refused; i++) begin
      logic [N-1:0] v = N'(8'h11 * (i + 1));
      bit ok = 1'b0;
      exp_q.push_back(v);
      do @(negedge clk); while (din_ack);
      @(posedge clk);
      din_t = v; din_f = ~v;
      for (int c = 0; c < 20 && !ok; c++) begin
        @(negedge clk);
        if (din_ack) ok = 1'b1;
      end
      if (ok) begin
        accepted++;
        @(posedge clk);
        din_t = '0; din_f = '0;
        do @(negedge clk); while (din_ack);
      end else begin
        refused = 1'b1;
      end
    end
    chk(accepted == CAP, "R7 words accepted while stalled", 64'(accepted), 64'(CAP));
    chk(refused, "R7 extra word refused", 64'(refused), 64'd1);
    for (int c = 0; c < 3; c++) begin
      repeat (5) @(negedge clk);
      chk(dout_t == 8'h11 && (&(dout_t ^ dout_f)), "R7 output holds first word",
          64'(dout_t), 64'h11);
    end
    fork
      begin
        do @(negedge clk); while (!din_ack);
        @(posedge clk);
        din_t = '0; din_f = '0;
        do @(negedge clk); while (din_ack);
      end
      for (int i = 0; i <= CAP; i++) recv_expect("R7 drain order after stall");
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_partial();
    t_stream(24);
    t_repeat();
    t_capacity();
    t_stream(8);
    repeat (10) @(negedge clk);
    // R1
    chk(n_bad == 0, "R1 no illegal rail pair at output", 64'(n_bad), 64'd0);
    // R4
    chk(n_skip == 0, "R4 spacer between output words", 64'(n_skip), 64'd0);
    summary();
    $finish;
  end
endmodule